// File: doc/BRIEF.md
# Dual-Termination Bus Cycle Controller

This block is the master side of an external 32-bit bus. A request names an operand of one, two or four bytes, a byte address and a direction. The controller turns that request into one or more bus cycles. Each cycle raises an address strobe, then a data strobe, and waits until the slave ends it.

A slave ends a cycle in one of two ways. It can return a two-bit size acknowledge that also reports how wide its port is. The controller then moves only the bytes that port can take and starts follow-on cycles at the next address until the operand is complete. Or it can pulse a single synchronous terminate, which always means a full 32-bit port. Write bytes are placed on the byte lanes so that a port of any width finds them where it expects. Read bytes arrive on the upper lanes of narrow ports and are packed into the right-aligned result.

The state machine has five states. IDLE waits for a request. ADDR is the first strobe clock. DATA1 accepts only the synchronous terminate. DATA2 accepts either termination and repeats while no termination arrives. END negates the strobes and then either finishes or returns to ADDR for a follow-on cycle. The transitions are: IDLE to ADDR on a request, ADDR to DATA1, DATA1 to END on terminate, DATA1 to DATA2 otherwise, DATA2 to END on either termination, END to IDLE when no bytes remain, and END to ADDR when bytes remain.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of a cycle, `bus_as`, `bus_ds` and `done` are low and `req_ready` is high.
- R2: A cycle ended by the size acknowledge keeps `bus_as` high for at least three clocks. `bus_ack` = 2'b11 means no acknowledge and inserts wait states, so the cycle lasts max(3, k) strobe clocks when the acknowledge first appears in strobe clock k.
- R3: A cycle ended by `bus_sterm` keeps `bus_as` high for at least two clocks, max(2, k) in the same sense, and treats the slave as a 32-bit port.
- R4: Acknowledge codes: 2'b10 is an 8-bit port, 2'b01 a 16-bit port, 2'b00 a 32-bit port. A cycle moves min(remaining, W - (address mod W)) bytes, where W is the port width in bytes.
- R5: While bytes remain after a cycle, a follow-on cycle starts at the address advanced by the bytes moved, until the operand is done.
- R6: During every cycle `bus_siz` gives the remaining byte count: 2'b01 is one byte, 2'b10 two, 2'b11 three, 2'b00 four.
- R7: Read bytes are taken from lane o onward, where lane 0 is bits 31:24 and o is 0 for an 8-bit port, address bit 0 for a 16-bit port, and address bits 1..0 for a 32-bit port. `rdata` holds the operand right-aligned, first-addressed byte most significant, from the `done` clock until the next request.
- R8: Write lanes, for the next byte b0 and the bytes after it: lane 0 carries b0; lane 1 carries b0 if address bit 0 is set, else b1; lane 2 carries b0 for address bits 2 or 3, b1 for 1, b2 for 0; lane 3 carries b(3 - address bits 1..0). `req_wdata` supplies the operand right-aligned.
- R9: When `bus_sterm` and a size acknowledge appear in the same clock, the synchronous terminate wins and the cycle counts as a 32-bit transfer.
- R10: `bus_ds` is high only while `bus_as` is high. `bus_as` goes low in the clock after the termination is sampled. `done` is a one-clock pulse in that clock after the final cycle.
- R11: A request is taken only while `req_ready` is high. `req_len` codes: 2'b01 is one byte, 2'b10 two bytes, and any other value four bytes. `bus_as` rises in the clock after the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_len | input | 2 | Operand length code |
| req_addr | input | 32 | Byte address of the operand |
| req_wdata | input | 32 | Write operand, right-aligned |
| req_ready | output | 1 | Controller idle, request may be taken |
| done | output | 1 | Operand finished pulse |
| rdata | output | 32 | Read operand, right-aligned |
| bus_addr | output | 32 | Bus address of the current cycle |
| bus_siz | output | 2 | Remaining byte count |
| bus_rd | output | 1 | 1 for a read cycle |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_dout | output | 32 | Write data on the byte lanes |
| bus_din | input | 32 | Read data from the slave |
| bus_ack | input | 2 | Size acknowledge from the slave |
| bus_sterm | input | 1 | Synchronous terminate, active high |

## Verification
A request taken at one rising edge raises `bus_as` in the very next clock. A termination sampled at an edge shows up one clock later as `bus_as` low, an advanced `bus_addr` and a smaller `bus_siz`, together with `done` and a valid `rdata` when it was the last cycle. The modelled slave counts strobe clocks at each falling edge and raises its termination after a set number of wait clocks. It records the address, size and write lanes while the strobe is high and scores the cycle at the first falling edge with the strobe low. The result checks wait for the `done` falling edge, and the memory and cycle-count checks wait one more falling edge, so every check samples settled values.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int BCC_LANES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA1,
        ST_DATA2,
        ST_END
    } bcc_state_e;

    typedef enum logic [1:0] {
        PW_32   = 2'b00,
        PW_16   = 2'b01,
        PW_8    = 2'b10,
        PW_NONE = 2'b11
    } port_ack_e;

    function automatic logic [2:0] len_to_bytes(input logic [1:0] len);
        unique case (len)
            2'b01:   return 3'd1;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bcc_xfer_calc.sv
module bcc_xfer_calc
    import bcc_pkg::*;
(
    input  logic [1:0] width,
    input  logic [1:0] addr_lo,
    input  logic [2:0] rem,
    output logic [2:0] n_bytes,
    output logic [1:0] lane_off
);
    logic [2:0] span;

    always_comb begin
        unique case (width)
            PW_8: begin
                span     = 3'd1;
                lane_off = 2'd0;
            end
            PW_16: begin
                span     = 3'd2 - {2'b00, addr_lo[0]};
                lane_off = {1'b0, addr_lo[0]};
            end
            default: begin
                span     = 3'd4 - {1'b0, addr_lo};
                lane_off = addr_lo;
            end
        endcase
        n_bytes = (rem < span) ? rem : span;
    end
endmodule

// File: rtl/bcc_wr_steer.sv
module bcc_wr_steer
    import bcc_pkg::*;
(
    input  logic [31:0] wbuf,
    input  logic [1:0]  addr_lo,
    output logic [31:0] dout
);
    logic [7:0] byt [BCC_LANES];

    function automatic logic [1:0] pick(input int lane, input logic [1:0] a);
        unique case (lane)
            0:       return 2'd0;
            1:       return a[0] ? 2'd0 : 2'd1;
            2:       return a[1] ? 2'd0 : (a[0] ? 2'd1 : 2'd2);
            default: return 2'd3 - a;
        endcase
    endfunction

    for (genvar g = 0; g < BCC_LANES; g++) begin : g_lane
        assign byt[g] = wbuf[31 - 8*g -: 8];
        assign dout[31 - 8*g -: 8] = byt[pick(g, addr_lo)];
    end
endmodule

// File: rtl/bcc_rd_merge.sv
module bcc_rd_merge (
    input  logic [31:0] rbuf,
    input  logic [31:0] din,
    input  logic [1:0]  lane_off,
    input  logic [2:0]  n_bytes,
    output logic [31:0] rbuf_nxt
);
    logic [31:0] aligned;
    logic [5:0]  sh_keep;
    logic [5:0]  sh_take;

    always_comb begin
        aligned  = din << {lane_off, 3'b000};
        sh_keep  = {n_bytes, 3'b000};
        sh_take  = 6'd32 - {n_bytes, 3'b000};
        rbuf_nxt = (rbuf << sh_keep) | (aligned >> sh_take);
    end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [31:0]       rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_siz,
    output logic              bus_rd,
    output logic              bus_as,
    output logic              bus_ds,
    output logic [31:0]       bus_dout,
    input  logic [31:0]       bus_din,
    input  logic [1:0]        bus_ack,
    input  logic              bus_sterm
);
    bcc_state_e        state, state_nxt;
    logic [ADDR_W-1:0] cur_addr;
    logic [2:0]        rem;
    logic [31:0]       wbuf, rbuf, rbuf_nxt;
    logic              is_wr;
    logic              sync_hit, ack_hit, term;
    logic [1:0]        eff_width;
    logic [2:0]        n_bytes;
    logic [1:0]        lane_off;
    logic [2:0]        load_bytes;
    logic [5:0]        load_sh;

    // termination decode; the synchronous terminate outranks the acknowledge
    always_comb begin
        sync_hit  = bus_sterm && (state == ST_DATA1 || state == ST_DATA2);
        ack_hit   = !sync_hit && state == ST_DATA2 && bus_ack != PW_NONE;
        term      = sync_hit || ack_hit;
        eff_width = sync_hit ? PW_32 : bus_ack;
    end

    bcc_xfer_calc u_calc (
        .width   (eff_width),
        .addr_lo (cur_addr[1:0]),
        .rem     (rem),
        .n_bytes (n_bytes),
        .lane_off(lane_off)
    );

    bcc_rd_merge u_merge (
        .rbuf    (rbuf),
        .din     (bus_din),
        .lane_off(lane_off),
        .n_bytes (n_bytes),
        .rbuf_nxt(rbuf_nxt)
    );

    bcc_wr_steer u_steer (
        .wbuf   (wbuf),
        .addr_lo(cur_addr[1:0]),
        .dout   (bus_dout)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nxt = ST_ADDR;
            ST_ADDR:  state_nxt = ST_DATA1;
            ST_DATA1: state_nxt = term ? ST_END : ST_DATA2;
            ST_DATA2: if (term) state_nxt = ST_END;
            ST_END:   state_nxt = (rem == 3'd0) ? ST_IDLE : ST_ADDR;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        load_bytes = len_to_bytes(req_len);
        load_sh    = 6'd32 - {load_bytes, 3'b000};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem      <= 3'd0;
            wbuf     <= '0;
            rbuf     <= '0;
            is_wr    <= 1'b0;
        end else if (state == ST_IDLE && req_valid) begin
            cur_addr <= req_addr;
            rem      <= load_bytes;
            wbuf     <= req_wdata << load_sh;
            rbuf     <= '0;
            is_wr    <= req_write;
        end else if (term) begin
            cur_addr <= cur_addr + ADDR_W'(n_bytes);
            rem      <= rem - n_bytes;
            wbuf     <= wbuf << {n_bytes, 3'b000};
            if (!is_wr) rbuf <= rbuf_nxt;
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        bus_as    = (state == ST_ADDR) || (state == ST_DATA1) || (state == ST_DATA2);
        bus_ds    = (state == ST_DATA1) || (state == ST_DATA2);
        done      = (state == ST_END) && (rem == 3'd0);
        bus_addr  = cur_addr;
        bus_siz   = rem[1:0];
        bus_rd    = !is_wr;
        rdata     = rbuf;
    end

    // strobe-length counter used only by the timing assertions
    logic [2:0] as_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               as_len <= 3'd0;
        else if (!bus_as)         as_len <= 3'd0;
        else if (as_len != 3'd7)  as_len <= as_len + 3'd1;
    end

    a_r10_ds_within_as: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ds |-> bus_as);
    a_r10_as_negate: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> !bus_as);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_async_min: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |-> (as_len >= 3'd2));
    a_r3_sync_min: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |-> (as_len >= 3'd1));
    a_r5_rem_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> (rem < $past(rem)));
    a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_as && !bus_ds));
endmodule

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;

    typedef struct packed {
        logic        wr;
        logic [1:0]  len;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [2:0]  port;   // 0 sync, 1 8-bit, 2 16-bit, 3 32-bit, 4 both
        logic [2:0]  waits;
        logic [2:0]  ncyc;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b00, 4'd0, 32'h0,        3'd0, 3'd0, 3'd1},
        '{1'b0, 2'b00, 4'd0, 32'h0,        3'd1, 3'd0, 3'd4},
        '{1'b0, 2'b00, 4'd1, 32'h0,        3'd2, 3'd0, 3'd3},
        '{1'b0, 2'b00, 4'd1, 32'h0,        3'd3, 3'd1, 3'd2},
        '{1'b0, 2'b10, 4'd3, 32'h0,        3'd3, 3'd0, 3'd2},
        '{1'b0, 2'b01, 4'd5, 32'h0,        3'd2, 3'd2, 3'd1},
        '{1'b0, 2'b00, 4'd2, 32'h0,        3'd0, 3'd3, 3'd2},
        '{1'b1, 2'b00, 4'd4, 32'hA1B2C3D4, 3'd1, 3'd2, 3'd4},
        '{1'b1, 2'b10, 4'd1, 32'h0000BEEF, 3'd3, 3'd0, 3'd1},
        '{1'b1, 2'b10, 4'd3, 32'h0000CAFE, 3'd2, 3'd0, 3'd2},
        '{1'b1, 2'b00, 4'd2, 32'h01234567, 3'd2, 3'd1, 3'd2},
        '{1'b0, 2'b00, 4'd0, 32'h0,        3'd4, 3'd0, 3'd1},
        '{1'b1, 2'b01, 4'd7, 32'h0000005A, 3'd0, 3'd0, 3'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_len = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, done, bus_rd, bus_as, bus_ds;
    logic [31:0] rdata, bus_addr, bus_dout;
    logic [1:0]  bus_siz;
    logic [31:0] bus_din = '0;
    logic [1:0]  bus_ack = 2'b11;
    logic        bus_sterm = 1'b0;

    always #4 clk = ~clk;

    bus_cycle_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bus_siz(bus_siz), .bus_rd(bus_rd), .bus_as(bus_as), .bus_ds(bus_ds),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack), .bus_sterm(bus_sterm)
    );

    int checks = 0, failures = 0;
    logic [7:0] mem [16];
    logic [2:0] cur_port = 3'd0, cur_waits = 3'd0;
    int   s_rem = 0, s_addr = 0, ncyc = 0, cnt = 0;
    logic pend = 1'b0;
    logic [31:0] lat_addr, lat_dout;
    logic [1:0]  lat_siz;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mem_init();
        for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i);
    endtask

    function automatic int lbytes(input logic [1:0] len);
        return (len == 2'b01) ? 1 : (len == 2'b10) ? 2 : 4;
    endfunction

    // modelled slave: drives at falling edges, scores a cycle when the strobe drops
    always @(negedge clk) begin
        if (!rst_n) begin
            cnt = 0; pend = 1'b0; bus_ack <= 2'b11; bus_sterm <= 1'b0;
        end else if (bus_as) begin
            cnt++;
            if (cnt == 1) begin
                chk(bus_siz == 2'(s_rem), "R6 size code", {30'd0, bus_siz}, 32'(s_rem[1:0]));
                chk(bus_addr == 32'(s_addr), "R5 cycle address", bus_addr, 32'(s_addr));
            end
            lat_addr = bus_addr; lat_dout = bus_dout; lat_siz = bus_siz; pend = 1'b1;
            case (cur_port)
                3'd1: bus_din <= {mem[bus_addr[3:0]], 24'h0};
                3'd2: bus_din <= {mem[{bus_addr[3:1], 1'b0}], mem[{bus_addr[3:1], 1'b1}], 16'h0};
                default: bus_din <= {mem[{bus_addr[3:2], 2'd0}], mem[{bus_addr[3:2], 2'd1}],
                                     mem[{bus_addr[3:2], 2'd2}], mem[{bus_addr[3:2], 2'd3}]};
            endcase
            if (cnt > int'(cur_waits)) begin
                case (cur_port)
                    3'd0: bus_sterm <= 1'b1;
                    3'd1: bus_ack <= 2'b10;
                    3'd2: bus_ack <= 2'b01;
                    3'd3: bus_ack <= 2'b00;
                    default: begin bus_ack <= 2'b10; bus_sterm <= 1'b1; end
                endcase
            end
        end else begin
            if (pend) begin
                int w, a, n, o, minc, expc;
                w = (cur_port == 3'd1) ? 1 : (cur_port == 3'd2) ? 2 : 4;
                a = int'(lat_addr[1:0]) % w;
                n = (s_rem < w - a) ? s_rem : w - a;
                o = (w == 1) ? 0 : a;
                if (!req_write)
                    ;
                else
                    for (int i = 0; i < n; i++)
                        mem[4'(lat_addr[3:0] + 4'(i))] = lat_dout[31 - 8*(o+i) -: 8];
                minc = (cur_port == 3'd0 || cur_port == 3'd4) ? 2 : 3;
                expc = (int'(cur_waits) + 1 > minc) ? int'(cur_waits) + 1 : minc;
                if (cur_port == 3'd4)      chk(cnt == expc, "R9 sterm wins over ack", 32'(cnt), 32'(expc));
                else if (cur_port == 3'd0) chk(cnt == expc, "R3 sync strobe length", 32'(cnt), 32'(expc));
                else                       chk(cnt == expc, "R2 async strobe length", 32'(cnt), 32'(expc));
                s_rem  = s_rem - n;
                s_addr = s_addr + n;
                ncyc++;
            end
            pend = 1'b0; cnt = 0; bus_ack <= 2'b11; bus_sterm <= 1'b0;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        mem_init();
        repeat (3) @(negedge clk);
        chk(!bus_as && !bus_ds, "R1 strobes low in reset", {30'd0, bus_as, bus_ds}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done, "R1 idle after reset", {30'd0, req_ready, done}, 32'd2);
        repeat (4) @(negedge clk);
        chk(!bus_as, "R11 no cycle without request", {31'd0, bus_as}, 32'd0);

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            int lb, guard;
            logic [31:0] expd, got;
            mem_init();
            cur_port = VECS[v].port; cur_waits = VECS[v].waits;
            lb = lbytes(VECS[v].len);
            s_rem = lb; s_addr = int'(VECS[v].addr); ncyc = 0;
            req_write = VECS[v].wr; req_len = VECS[v].len;
            req_addr = {28'd0, VECS[v].addr}; req_wdata = VECS[v].wdata;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            guard = 0;
            while (!done && guard < 200) begin @(negedge clk); guard++; end
            chk(done, "R10 done reached", {31'd0, done}, 32'd1);
            if (!VECS[v].wr) begin
                expd = '0;
                for (int i = 0; i < lb; i++) expd = (expd << 8) | 32'(8'h10 + 8'(VECS[v].addr) + 8'(i));
                chk(rdata == expd, "R7 read assembly", rdata, expd);
            end
            chk(!bus_as, "R10 strobe low at done", {31'd0, bus_as}, 32'd0);
            @(negedge clk);
            chk(!done, "R10 done single pulse", {31'd0, done}, 32'd0);
            if (VECS[v].wr) begin
                got = '0;
                for (int i = 0; i < lb; i++) got = (got << 8) | 32'(mem[VECS[v].addr + 4'(i)]);
                expd = (lb == 4) ? VECS[v].wdata : (VECS[v].wdata & ((32'd1 << (8*lb)) - 32'd1));
                chk(got == expd, "R8 write lanes", got, expd);
            end
            chk(ncyc == int'(VECS[v].ncyc), "R4 cycle count from port width", 32'(ncyc), 32'(VECS[v].ncyc));
        end

        // directed: reset in the middle of a long wait
        cur_port = 3'd1; cur_waits = 3'd7;
        s_rem = 4; s_addr = 0; req_write = 1'b0; req_len = 2'b00; req_addr = '0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_as && bus_ds, "R2 waits while ack idle", {30'd0, bus_as, bus_ds}, 32'd3);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!bus_as && !bus_ds && req_ready && !done, "R1 reset mid-cycle",
            {28'd0, bus_as, bus_ds, req_ready, done}, 32'd2);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule